// File: doc/BRIEF.md
# Dual-Bus Instruction Fetch Router

This block sits between a processor's instruction-fetch stage and two memory ports that share one flat 24-bit byte address space. The wide program port returns a 32-bit word for each access. The narrow data port moves one byte per access, and the processor's load/store path also uses it. For each fetch request the router decodes the start address and picks a port. It then gathers up to four instruction bytes into a fetch buffer and presents them to the decoder with a valid flag and a byte count.

Each port has a stall input. A request stays on the port, with a steady address, until a cycle in which stall is low. On the byte port, data loads and stores win over instruction fetches. An instruction group that was interrupted picks up at its next byte. Loads that address the program region are served on the wide port, which lets constant tables be read from program memory. A flush input, raised on a branch, empties the buffer at once. Any access already on a port still runs its handshake to the end, and its data is thrown away.

Top module: `fetch_router`

## Requirements
- R1: A fetch whose start address is below RAM_LIMIT is served on the byte port. Any other start address is served on the wide port.
- R2: A wide fetch makes one program-port access at the word-aligned address. It presents fb_count = 4 - addr[1:0]. Byte lane i of fb_data (bits 8i+7..8i) holds the byte at start address + i. On the port, lane i of pm_rdata is the byte at pm_addr + i.
- R3: A byte-port fetch collects one byte per completed data-port access, at consecutive addresses, into lanes 0, 1, 2, 3 in that order. It presents fb_count = min(4, RAM_LIMIT - start).
- R4: While a port's request is up and its stall is high, the request stays up and its address is unchanged in the next cycle. An access completes in a cycle with request high and stall low.
- R5: On the byte port, a waiting load or store is granted before the next byte of a fetch. The fetch then continues with its following byte and gives correct data.
- R6: A load at or above RAM_LIMIT reads the program port and returns lane ld_addr[1:0] of the word. A store at or above RAM_LIMIT completes in the same cycle without any port access.
- R7: fb_valid is low in the cycle after flush. An access already on a port keeps its request and address until it completes, and its data is discarded. The next fetch returns correct bytes.
- R8: While fb_valid is high and neither fb_ack nor flush is raised, fb_valid, fb_count and fb_data hold.
- R9: During reset no port request is raised and fb_valid is low. After reset, fetch_rdy is high.
- R10: One fetch never has live requests on both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Start a fetch group; taken when fetch_rdy is high |
| fetch_addr | input | 24 | Start byte address of the group |
| fetch_rdy | output | 1 | Router idle, ready to take a fetch |
| flush | input | 1 | Discard buffer and abandon the current group |
| fb_valid | output | 1 | Fetch buffer holds a complete group |
| fb_count | output | 3 | Number of valid bytes (1 to 4) |
| fb_data | output | 32 | Instruction bytes, first byte in lane 0 |
| fb_ack | input | 1 | Decoder has consumed the buffer |
| ld_req | input | 1 | Data access request, held until ld_done |
| ld_we | input | 1 | 1 for store, 0 for load |
| ld_addr | input | 24 | Data access byte address |
| ld_wdata | input | 8 | Store data |
| ld_rdata | output | 8 | Load data, valid with ld_done |
| ld_done | output | 1 | Data access completes this cycle |
| pm_req | output | 1 | Program port request |
| pm_addr | output | 24 | Program port word-aligned address |
| pm_rdata | input | 32 | Program port read word |
| pm_stall | input | 1 | Program port not ready |
| dm_req | output | 1 | Byte port request |
| dm_we | output | 1 | Byte port write enable |
| dm_addr | output | 24 | Byte port address |
| dm_wdata | output | 8 | Byte port write data |
| dm_rdata | input | 8 | Byte port read data |
| dm_stall | input | 1 | Byte port not ready |

## Verification
The hardest case to reach from the ports is a load that arrives while a fetch byte is already on the byte port and stalled, so that one grant decision meets both the in-flight byte and the waiting load. A close second is a flush that lands while an access is stalled on a port. Directed sequences bring both about. The bench holds both stalls high, starts a RAM fetch, raises a load or a flush, then releases the stalls and reads the order of byte-port completions and the bytes returned. Random stall lengths on both ports, with fetches and loads running in parallel, cover the other interleavings.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    FU_IDLE = 2'd0,
    FU_WIDE = 2'd1,
    FU_BYTE = 2'd2,
    FU_FULL = 2'd3
  } fu_state_e;
endpackage

// File: rtl/fr_port_arb.sv
// Two-requester port arbiter: side a (data access) wins over side b (fetch)
// whenever the port is free; a stalled access is latched until it completes.
module fr_port_arb #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic [AW-1:0] a_addr,
  input  logic          b_req,
  input  logic [AW-1:0] b_addr,
  input  logic          b_kill,
  input  logic          stall,
  output logic          port_req,
  output logic [AW-1:0] port_addr,
  output logic          a_own,
  output logic          a_done,
  output logic          b_done,
  output logic          b_live
);
  logic          busy_q, busy_d;
  logic          own_q, own_d;
  logic          drop_q, drop_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          cur_own, fire;

  always_comb begin
    cur_own   = busy_q ? own_q : (!a_req && b_req);
    port_req  = busy_q | a_req | b_req;
    port_addr = busy_q ? addr_q : (a_req ? a_addr : b_addr);
    fire      = port_req & ~stall;
    busy_d    = busy_q;
    own_d     = own_q;
    drop_d    = drop_q;
    addr_d    = addr_q;
    if (fire) begin
      busy_d = 1'b0;
      drop_d = 1'b0;
    end else if (port_req) begin
      busy_d = 1'b1;
      own_d  = cur_own;
      addr_d = port_addr;
      drop_d = (drop_q & busy_q) | (b_kill & cur_own);
    end
  end

  assign a_own  = port_req & ~cur_own;
  assign a_done = fire & ~cur_own;
  assign b_done = fire & cur_own & ~drop_q;
  assign b_live = port_req & cur_own & ~drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= 1'b0;
      drop_q <= 1'b0;
      addr_q <= '0;
    end else if (port_req) begin
      busy_q <= busy_d;
      own_q  <= own_d;
      drop_q <= drop_d;
      addr_q <= addr_d;
    end
  end

  // R4: a stalled request stays on the port with the same address
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_req && stall |=> port_req && $stable(port_addr));

  // R7: a fetch access killed while stalled never reports its data
  assert_kill_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_kill && port_req && cur_own && stall |=> !b_done);
endmodule

// File: rtl/fr_fetch_unit.sv
module fr_fetch_unit
  import fr_pkg::*;
#(
  parameter int          AW        = 24,
  parameter int          PW        = 32,
  parameter logic [AW-1:0] LIMIT   = 24'h000400,
  localparam int         NB        = PW / 8,
  localparam int         OW        = $clog2(NB),
  localparam int         CW        = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          flush,
  input  logic          fb_ack,
  output logic          fetch_rdy,
  output logic          fb_valid,
  output logic [CW-1:0] fb_count,
  output logic [PW-1:0] fb_data,
  output logic          pm_b_req,
  output logic [AW-1:0] pm_b_addr,
  input  logic          pm_b_done,
  input  logic [PW-1:0] pm_rdata,
  output logic          dm_b_req,
  output logic [AW-1:0] dm_b_addr,
  input  logic          dm_b_done,
  input  logic [7:0]    dm_rdata
);
  localparam logic [CW-1:0] NB_C = CW'(NB);

  fu_state_e     st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] need_q, need_d;
  logic [PW-1:0] buf_q, buf_d;
  logic [AW-1:0] span;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    need_d    = need_q;
    buf_d     = buf_q;
    pm_b_req  = 1'b0;
    dm_b_req  = 1'b0;
    pm_b_addr = {addr_q[AW-1:OW], {OW{1'b0}}};
    dm_b_addr = addr_q;
    span      = LIMIT - fetch_addr;
    if (flush) begin
      st_d  = FU_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        FU_IDLE: if (fetch_req) begin
          addr_d = fetch_addr;
          cnt_d  = '0;
          buf_d  = '0;
          if (fetch_addr < LIMIT) begin
            st_d   = FU_BYTE;
            need_d = (span >= AW'(NB)) ? NB_C : span[CW-1:0];
          end else begin
            st_d   = FU_WIDE;
            need_d = NB_C - CW'(fetch_addr[OW-1:0]);
          end
        end
        FU_WIDE: begin
          pm_b_req = 1'b1;
          if (pm_b_done) begin
            buf_d = pm_rdata >> {addr_q[OW-1:0], 3'b000};
            cnt_d = need_q;
            st_d  = FU_FULL;
          end
        end
        FU_BYTE: begin
          dm_b_req = 1'b1;
          if (dm_b_done) begin
            buf_d[{cnt_q[OW-1:0], 3'b000} +: 8] = dm_rdata;
            cnt_d  = cnt_q + 1'b1;
            addr_d = addr_q + 1'b1;
            if (cnt_q + 1'b1 == need_q) st_d = FU_FULL;
          end
        end
        FU_FULL: if (fb_ack) st_d = FU_IDLE;
        default: st_d = FU_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FU_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      need_q <= '0;
      buf_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      need_q <= need_d;
      buf_q  <= buf_d;
    end
  end

  assign fetch_rdy = (st_q == FU_IDLE);
  assign fb_valid  = (st_q == FU_FULL);
  assign fb_count  = cnt_q;
  assign fb_data   = buf_q;

  // R8: a presented group holds until consumed or flushed
  assert_fb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_ack && !flush |=> fb_valid && $stable(fb_data) && $stable(fb_count));

  // R7: flush empties the buffer in the next cycle
  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fb_valid);

  // R3: a presented count is always between 1 and NB
  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> (fb_count != '0) && (fb_count <= NB_C));

  // R1: byte-port fetch addresses stay inside the RAM region
  assert_ram_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dm_b_req |-> dm_b_addr < LIMIT);
endmodule

// File: rtl/fetch_router.sv
module fetch_router #(
  parameter int AW        = 24,
  parameter int PW        = 32,
  parameter int RAM_LIMIT = 32'h0000_0400,
  localparam int NB       = PW / 8,
  localparam int OW       = $clog2(NB),
  localparam int CW       = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_rdy,
  input  logic          flush,
  output logic          fb_valid,
  output logic [CW-1:0] fb_count,
  output logic [PW-1:0] fb_data,
  input  logic          fb_ack,
  input  logic          ld_req,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_wdata,
  output logic [7:0]    ld_rdata,
  output logic          ld_done,
  output logic          pm_req,
  output logic [AW-1:0] pm_addr,
  input  logic [PW-1:0] pm_rdata,
  input  logic          pm_stall,
  output logic          dm_req,
  output logic          dm_we,
  output logic [AW-1:0] dm_addr,
  output logic [7:0]    dm_wdata,
  input  logic [7:0]    dm_rdata,
  input  logic          dm_stall
);
  localparam logic [AW-1:0] LIM = AW'(RAM_LIMIT);

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  logic          ld_ram, dm_a_req, pm_a_req, pm_store;
  logic [AW-1:0] pm_a_addr;
  logic          pm_b_req, dm_b_req, pm_b_done, dm_b_done;
  logic [AW-1:0] pm_b_addr, dm_b_addr;
  logic          pm_a_done, dm_a_done, pm_a_own, dm_a_own;
  logic          pm_b_live, dm_b_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign ld_ram    = ld_addr < LIM;
  assign dm_a_req  = ld_req & ld_ram;
  assign pm_a_req  = ld_req & ~ld_ram & ~ld_we;
  assign pm_store  = ld_req & ~ld_ram & ld_we;
  assign pm_a_addr = {ld_addr[AW-1:OW], {OW{1'b0}}};

  fr_fetch_unit #(.AW(AW), .PW(PW), .LIMIT(LIM)) u_fetch (
    .clk(clk), .rst_n(rst_i_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .flush(flush), .fb_ack(fb_ack),
    .fetch_rdy(fetch_rdy), .fb_valid(fb_valid), .fb_count(fb_count), .fb_data(fb_data),
    .pm_b_req(pm_b_req), .pm_b_addr(pm_b_addr), .pm_b_done(pm_b_done), .pm_rdata(pm_rdata),
    .dm_b_req(dm_b_req), .dm_b_addr(dm_b_addr), .dm_b_done(dm_b_done), .dm_rdata(dm_rdata)
  );

  fr_port_arb #(.AW(AW)) u_pm_arb (
    .clk(clk), .rst_n(rst_i_n),
    .a_req(pm_a_req), .a_addr(pm_a_addr),
    .b_req(pm_b_req), .b_addr(pm_b_addr), .b_kill(flush),
    .stall(pm_stall), .port_req(pm_req), .port_addr(pm_addr),
    .a_own(pm_a_own), .a_done(pm_a_done), .b_done(pm_b_done), .b_live(pm_b_live)
  );

  fr_port_arb #(.AW(AW)) u_dm_arb (
    .clk(clk), .rst_n(rst_i_n),
    .a_req(dm_a_req), .a_addr(ld_addr),
    .b_req(dm_b_req), .b_addr(dm_b_addr), .b_kill(flush),
    .stall(dm_stall), .port_req(dm_req), .port_addr(dm_addr),
    .a_own(dm_a_own), .a_done(dm_a_done), .b_done(dm_b_done), .b_live(dm_b_live)
  );

  assign dm_we    = dm_a_own & ld_we;
  assign dm_wdata = ld_wdata;
  assign ld_rdata = ld_ram ? dm_rdata : pm_rdata[{ld_addr[OW-1:0], 3'b000} +: 8];
  assign ld_done  = dm_a_done | pm_a_done | pm_store;

  // R10: one fetch never holds live requests on both ports
  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(pm_b_live && dm_b_live));

  // R6: a program-region store never takes the program port
  assert_store_quiet_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    pm_store |-> !pm_a_own);

  // R9: no port activity while the internal reset is held
  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_i_n |-> !pm_req && !dm_req);
endmodule

// File: tb/tb_fetch_router.sv
module tb_fetch_router;
  localparam int CLK_P = 10;
  localparam int AW    = 24;
  localparam int RL    = 32'h400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_rdy;
  logic          flush = 1'b0;
  logic          fb_valid;
  logic [2:0]    fb_count;
  logic [31:0]   fb_data;
  logic          fb_ack = 1'b0;
  logic          ld_req = 1'b0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_wdata = '0;
  logic [7:0]    ld_rdata;
  logic          ld_done;
  logic          pm_req;
  logic [AW-1:0] pm_addr;
  logic [31:0]   pm_rdata;
  logic          pm_stall = 1'b0;
  logic          dm_req, dm_we;
  logic [AW-1:0] dm_addr;
  logic [7:0]    dm_wdata, dm_rdata;
  logic          dm_stall = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int stall_mode = 0;   // 0 random, 1 forced stall, 2 no stall
  bit mon_excl = 1'b0;
  bit log_en = 1'b0;
  int log_n = 0;
  logic [AW-1:0] dm_log [0:15];
  int pm_fires = 0;
  int dm_fires = 0;
  logic [7:0] ram [0:RL-1];

  fetch_router #(.RAM_LIMIT(RL)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdy(fetch_rdy),
    .flush(flush), .fb_valid(fb_valid), .fb_count(fb_count), .fb_data(fb_data), .fb_ack(fb_ack),
    .ld_req(ld_req), .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
    .ld_rdata(ld_rdata), .ld_done(ld_done),
    .pm_req(pm_req), .pm_addr(pm_addr), .pm_rdata(pm_rdata), .pm_stall(pm_stall),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata), .dm_stall(dm_stall)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pbyte(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_byte(logic [AW-1:0] a);
    return (a < AW'(RL)) ? ram[a[9:0]] : pbyte(a);
  endfunction

  function automatic int exp_count(logic [AW-1:0] a);
    if (a < AW'(RL)) return (RL - int'(a) >= 4) ? 4 : RL - int'(a);
    return 4 - int'(a[1:0]);
  endfunction

  // behavioural memories
  assign pm_rdata = {pbyte(pm_addr + 24'd3), pbyte(pm_addr + 24'd2),
                     pbyte(pm_addr + 24'd1), pbyte(pm_addr)};
  assign dm_rdata = ram[dm_addr[9:0]];

  always @(posedge clk) begin
    #1;
    case (stall_mode)
      1: begin pm_stall = 1'b1; dm_stall = 1'b1; end
      2: begin pm_stall = 1'b0; dm_stall = 1'b0; end
      default: begin
        pm_stall = ($urandom_range(0, 99) < 45);
        dm_stall = ($urandom_range(0, 99) < 45);
      end
    endcase
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // port monitors: completions, stores, R4 hold, R10 exclusivity
  logic          pm_prev_st = 1'b0, dm_prev_st = 1'b0;
  logic [AW-1:0] pm_prev_a = '0, dm_prev_a = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pm_prev_st) chk(pm_req && pm_addr == pm_prev_a, "R4", "pm hold", pm_addr, pm_prev_a);
      if (dm_prev_st) chk(dm_req && dm_addr == dm_prev_a, "R4", "dm hold", dm_addr, dm_prev_a);
      if (mon_excl) chk(!(pm_req && dm_req), "R10", "both ports", {pm_req, dm_req}, 0);
      if (pm_req && !pm_stall) pm_fires++;
      if (dm_req && !dm_stall) begin
        dm_fires++;
        if (dm_we) ram[dm_addr[9:0]] = dm_wdata;
        if (log_en && log_n < 16) begin dm_log[log_n] = dm_addr; log_n++; end
      end
    end
    pm_prev_st = rst_n && pm_req && pm_stall;
    pm_prev_a  = pm_addr;
    dm_prev_st = rst_n && dm_req && dm_stall;
    dm_prev_a  = dm_addr;
  end

  task automatic do_fetch(logic [AW-1:0] a, int hold);
    logic [31:0] mask, expd, snap;
    int n;
    string tag;
    tag = (a < AW'(RL)) ? "R1,R3" : "R1,R2";
    do @(negedge clk); while (!fetch_rdy);
    fetch_addr = a;
    fetch_req = 1'b1;
    @(posedge clk); #1 fetch_req = 1'b0;
    do @(negedge clk); while (!fb_valid);
    n = exp_count(a);
    mask = '0; expd = '0;
    for (int i = 0; i < n; i++) begin
      mask[8*i +: 8] = 8'hFF;
      expd[8*i +: 8] = exp_byte(a + AW'(i));
    end
    chk(int'(fb_count) == n, tag, "count", 32'(fb_count), 32'(n));
    chk((fb_data & mask) == expd, tag, "bytes", fb_data & mask, expd);
    if (hold > 0) begin
      snap = fb_data;
      repeat (hold) @(negedge clk);
      chk(fb_valid && fb_data == snap && int'(fb_count) == n, "R8", "hold", fb_data, snap);
    end
    fb_ack = 1'b1;
    @(posedge clk); #1 fb_ack = 1'b0;
  endtask

  task automatic do_load(logic [AW-1:0] a, logic we, logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    ld_addr = a; ld_we = we; ld_wdata = wd; ld_req = 1'b1;
    #1;
    forever begin
      if (ld_done) begin
        rd = ld_rdata;
        @(posedge clk); #1 ld_req = 1'b0;
        break;
      end
      @(negedge clk); #1;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    int pf, df;
    void'($urandom(32'd20240611));
    for (int i = 0; i < RL; i++) ram[i] = 8'(i * 7 + 3);

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!pm_req && !dm_req && !fb_valid, "R9", "reset outputs", {pm_req, dm_req, fb_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(fetch_rdy && !fb_valid, "R9", "ready after reset", {fetch_rdy, fb_valid}, 32'h2);

    // R2: wide fetches at every offset and at the top of the space
    stall_mode = 0;
    for (int o = 0; o < 4; o++) do_fetch(24'h001000 + AW'(o), 0);
    do_fetch(24'hFFFFFE, 0);
    do_fetch(24'h000400, 0);
    // R3: byte fetches, including those cut at RAM_LIMIT
    do_fetch(24'h000010, 0);
    do_fetch(24'h0003FE, 0);
    do_fetch(24'h0003FF, 0);
    // R8: buffer holds without acknowledge
    do_fetch(24'h002002, 3);
    do_fetch(24'h000033, 3);

    // R5: data access pre-empts the next fetch byte
    stall_mode = 1; log_n = 0; log_en = 1'b1;
    fork
      do_fetch(24'h000020, 0);
      begin repeat (4) @(negedge clk); do_load(24'h0001F0, 1'b0, 8'h00, rd); end
      begin repeat (8) @(posedge clk); #2 stall_mode = 2; end
    join
    log_en = 1'b0;
    chk(log_n >= 3 && dm_log[1] == 24'h0001F0, "R5", "load granted first", dm_log[1], 24'h0001F0);
    chk(dm_log[2] == 24'h000021, "R5", "fetch resumes", dm_log[2], 24'h000021);
    chk(rd == ram[10'h1F0], "R5", "load data", rd, ram[10'h1F0]);

    // R6: far load and program-region store
    stall_mode = 0;
    do_load(24'h002345, 1'b0, 8'h00, rd);
    chk(rd == pbyte(24'h002345), "R6", "far load", rd, pbyte(24'h002345));
    do_load(24'h00ABCE, 1'b0, 8'h00, rd);
    chk(rd == pbyte(24'h00ABCE), "R6", "far load lane2", rd, pbyte(24'h00ABCE));
    @(negedge clk);
    pf = pm_fires; df = dm_fires;
    do_load(24'h005000, 1'b1, 8'hC3, rd);
    @(negedge clk);
    chk(pm_fires == pf && dm_fires == df, "R6", "store no port", pm_fires + dm_fires, pf + df);

    // R7: flush while a byte access is stalled
    stall_mode = 1;
    do @(negedge clk); while (!fetch_rdy);
    fetch_addr = 24'h000040; fetch_req = 1'b1;
    @(posedge clk); #1 fetch_req = 1'b0;
    repeat (3) @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    chk(!fb_valid && fetch_rdy, "R7", "flush state", {fb_valid, fetch_rdy}, 32'h1);
    chk(dm_req && dm_addr == 24'h000040, "R7", "issued access kept", dm_addr, 24'h000040);
    stall_mode = 0;
    do_fetch(24'h000050, 0);
    do_fetch(24'h003001, 0);
    // R7: flush with a full buffer
    do @(negedge clk); while (!fetch_rdy);
    fetch_addr = 24'h003000; fetch_req = 1'b1;
    @(posedge clk); #1 fetch_req = 1'b0;
    do @(negedge clk); while (!fb_valid);
    flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    chk(!fb_valid, "R7", "flush full buffer", 32'(fb_valid), 0);
    do_fetch(24'h000101, 0);

    // R10 and R4: random fetches alone, random stalls
    mon_excl = 1'b1;
    for (int k = 0; k < 300; k++) begin
      int r = $urandom_range(0, 9);
      logic [AW-1:0] a;
      if (r < 4)       a = AW'($urandom_range(0, 32'h1FF));
      else if (r == 4) a = AW'(32'h3FC + $urandom_range(0, 3));
      else             a = AW'($urandom_range(32'h400, 32'hFFFFFF));
      do_fetch(a, $urandom_range(0, 2));
    end
    mon_excl = 1'b0;

    // mixed fetches and data accesses on both ports
    fork
      for (int k = 0; k < 150; k++) begin
        logic [AW-1:0] a;
        if ($urandom_range(0, 1) == 0) a = AW'($urandom_range(0, 32'h1FF));
        else                           a = AW'($urandom_range(32'h400, 32'hFFFFFF));
        do_fetch(a, 0);
      end
      for (int k = 0; k < 150; k++) begin
        logic [7:0] v;
        logic [AW-1:0] a;
        int t = $urandom_range(0, 3);
        if (t == 0) begin
          a = AW'($urandom_range(32'h400, 32'hFFFFFF));
          do_load(a, 1'b0, 8'h00, v);
          chk(v == pbyte(a), "R6", "mixed far load", v, pbyte(a));
        end else if (t == 1) begin
          a = AW'(32'h200 + $urandom_range(0, 255));
          do_load(a, 1'b1, 8'($urandom), v);
        end else if (t == 2) begin
          a = AW'($urandom_range(32'h200, 32'h3FF));
          do_load(a, 1'b0, 8'h00, v);
          chk(v == ram[a[9:0]], "R5", "mixed ram load", v, ram[a[9:0]]);
        end else begin
          a = AW'($urandom_range(32'h400, 32'hFFFFFF));
          do_load(a, 1'b1, 8'h11, v);
        end
      end
    join

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule